// File: doc/BRIEF.md
# Wake Event Power-Management Controller

This block is the sleep-side event logic of a network interface whose host can be powered off. While the block is in its power-management mode it watches a set of wake sources: general-purpose pins, the link-up indication from the PHY, and a one-cycle strobe from a magic-packet detector. When an enabled source fires, it latches a pending wake request. The request drives a power-management-event (PME) pin toward an embedded controller, either as a level or as a timed pulse. It also records the cause in a sticky per-source flag word.

The PHY-mode input moves the two reserved signalling pins. The PME output and the stay-or-resume select input sit on GPIO0/GPIO1 with the internal PHY, and on GPIO8/GPIO9 with an external PHY. The embedded controller answers a wake by pulling the active-low clear input low. This wipes the pending request and the flags. On the falling edge of that input, the select pin decides whether the block stays in power-management mode (1) or returns to normal operation (0). The PME pin can be driven push-pull (active high) or open-drain (active low, enable-only).

Top module: `wake_pme_ctrl`

## Requirements
- R1: After the system reset is released, the block is in power-management mode (`pme_mode`=1) and `wake_flags` is 0. The PME pin is not active, so with internal PHY and push-pull drive `gpio_oe`=0x001 and `gpio_out`=0.
- R2: With `phy_ext`=0 the PME output is GPIO0 and the mode-select input is GPIO1. With `phy_ext`=1 they are GPIO8 and GPIO9. Only the PME pin is ever output-enabled.
- R3: Wake-capable pins are GPIO2..GPIO10 with `phy_ext`=0, and only GPIO10 with `phy_ext`=1. No other pin raises a wake, whatever its enable bit.
- R4: With `phy_ext`=0, GPIO2..GPIO9 are active low: a high-to-low transition wakes. GPIO10 wakes on the transition into its active level, which is high when `g10_act_high`=1 and low when it is 0.
- R5: A pin wakes only when its bit in `wake_en` (bit i for GPIOi) is 1.
- R6: In power-management mode, a rising edge of `link_up` or a one-cycle `magic_pkt` strobe raises a wake. The PME becomes active one clock after the edge or strobe is sampled. A GPIO wake shows three clocks after the pin changes.
- R7: While `pme_mode`=0, no source raises a wake or sets a flag.
- R8: While `clr_n` is low, the pending request and `wake_flags` are cleared. This takes precedence over any wake in the same cycle.
- R9: On the clock that first samples `clr_n` low, `pme_mode` takes the synchronized value of the mode-select pin: 1 stays in power-management mode, 0 returns to normal operation.
- R10: With `pulse_mode`=0 the PME stays active from the wake until the clear.
- R11: With `pulse_mode`=1 the first wake after a clear makes the PME active for `pulse_len`+1 clocks. Further wakes before the next clear give no new pulse.
- R12: `wake_flags` is sticky until the clear. Bits 0..10 are GPIO0..GPIO10, bit 11 is link-up and bit 12 is magic packet.
- R13: With `open_drain`=0 the PME pin has its enable at 1 and drives the active-high PME. With `open_drain`=1 it drives 0 and its enable equals the PME.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| clr_n | input | 1 | Active-low clear from the embedded controller; falling edge samples mode-select |
| phy_ext | input | 1 | 1 = external PHY pin mapping |
| gpio_in | input | 11 | GPIO pin levels (asynchronous) |
| wake_en | input | 11 | Per-pin wake enables |
| g10_act_high | input | 1 | GPIO10 active level (1 = high) |
| link_up | input | 1 | PHY link indication |
| magic_pkt | input | 1 | One-cycle magic-packet strobe |
| pulse_mode | input | 1 | 1 = pulse signalling, 0 = level |
| pulse_len | input | 8 | Pulse length minus one, in clocks |
| open_drain | input | 1 | 1 = open-drain PME drive |
| gpio_out | output | 11 | GPIO output values |
| gpio_oe | output | 11 | GPIO output enables |
| pme_mode | output | 1 | 1 = power-management mode |
| wake_flags | output | 13 | Sticky wake-cause flags |

## Verification
The assertions check on every cycle that a low clear empties the request and the flags on the next clock. They check that flags never grow outside power-management mode, and that the mode bit follows the synchronized select pin on each clear edge. They also check the level-mode hold, that a pulse starts only together with a new request, the open-drain drive value, and that at most one pin is enabled. Pulse length, the pin relocation, the per-pin polarity and capability masks, and the three-clock GPIO latency are shown only by the bench's scenarios. In those scenarios the bench compares every output each clock against its behavioural model.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
   localparam int NGPIO     = 11;
   localparam int IDX_LINK  = 11;
   localparam int IDX_MAGIC = 12;
   localparam int NSRC      = 13;
   localparam int PIN_INT   = 0;
   localparam int PIN_EXT   = 8;
   localparam logic [NGPIO-1:0] CAP_INT = 11'b111_1111_1100;
   localparam logic [NGPIO-1:0] CAP_EXT = 11'b100_0000_0000;
endpackage

// File: rtl/wpc_sync.sv
module wpc_sync #(
   parameter int W      = 11,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("wpc_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/wpc_wake_detect.sv
module wpc_wake_detect
   import wpc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NGPIO-1:0] pin_s,
   input  logic             phy_ext,
   input  logic             g10_act_high,
   input  logic [NGPIO-1:0] wake_en,
   output logic [NGPIO-1:0] pin_hit
);
   logic [NGPIO-1:0] act, act_q, cap;

   generate
      for (genvar i = 0; i < NGPIO; i++) begin : g_pol
         if (i == NGPIO-1) begin : g_prog
            assign act[i] = g10_act_high ? pin_s[i] : ~pin_s[i];
         end else begin : g_low
            assign act[i] = ~pin_s[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q <= '1;
      else        act_q <= act;
   end

   assign cap     = phy_ext ? CAP_EXT : CAP_INT;
   assign pin_hit = act & ~act_q & cap & wake_en;
endmodule

// File: rtl/wpc_pme_out.sv
module wpc_pme_out
   import wpc_pkg::*;
#(
   parameter int PULSE_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trigger,
   input  logic               clearing,
   input  logic               pend,
   input  logic               pulse_mode,
   input  logic [PULSE_W-1:0] pulse_len,
   input  logic               phy_ext,
   input  logic               open_drain,
   output logic               pme_sig,
   output logic [NGPIO-1:0]   gpio_out,
   output logic [NGPIO-1:0]   gpio_oe
);
   logic               busy;
   logic [PULSE_W-1:0] remain;
   logic [NGPIO-1:0]   sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         remain <= '0;
      end else if (clearing) begin
         busy   <= 1'b0;
         remain <= '0;
      end else if (trigger) begin
         busy   <= 1'b1;
         remain <= pulse_len;
      end else if (busy) begin
         if (remain == '0) busy <= 1'b0;
         else              remain <= remain - 1'b1;
      end
   end

   assign pme_sig = pulse_mode ? busy : pend;

   generate
      for (genvar i = 0; i < NGPIO; i++) begin : g_pin
         if (i == PIN_INT || i == PIN_EXT) begin : g_pme
            assign sel[i] = phy_ext ? (i == PIN_EXT) : (i == PIN_INT);
         end else begin : g_none
            assign sel[i] = 1'b0;
         end
      end
   endgenerate

   assign gpio_out = open_drain ? '0 : (sel & {NGPIO{pme_sig}});
   assign gpio_oe  = open_drain ? (sel & {NGPIO{pme_sig}}) : sel;
endmodule

// File: rtl/wake_pme_ctrl.sv
module wake_pme_ctrl
   import wpc_pkg::*;
#(
   parameter int   PULSE_W      = 8,
   parameter int   SYNC_STAGES  = 2,
   parameter logic RESET_IN_PME = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_n,
   input  logic               phy_ext,
   input  logic [NGPIO-1:0]   gpio_in,
   input  logic [NGPIO-1:0]   wake_en,
   input  logic               g10_act_high,
   input  logic               link_up,
   input  logic               magic_pkt,
   input  logic               pulse_mode,
   input  logic [PULSE_W-1:0] pulse_len,
   input  logic               open_drain,
   output logic [NGPIO-1:0]   gpio_out,
   output logic [NGPIO-1:0]   gpio_oe,
   output logic               pme_mode,
   output logic [NSRC-1:0]    wake_flags
);
   localparam int SEL_INT = PIN_INT + 1;
   localparam int SEL_EXT = PIN_EXT + 1;

   generate
      if (PULSE_W < 1 || PULSE_W > 16) begin : g_bad_w
         $error("PULSE_W out of range");
      end
   endgenerate

   logic [NGPIO-1:0] pin_s, pin_hit;
   logic [NSRC-1:0]  src_hit;
   logic clr_q, link_q, pend, clearing, clr_fall, modesel, link_rise, any_hit, trigger, pme_sig;

   wpc_sync #(.W(NGPIO), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(gpio_in), .q(pin_s)
   );

   wpc_wake_detect u_det (
      .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .phy_ext(phy_ext),
      .g10_act_high(g10_act_high), .wake_en(wake_en), .pin_hit(pin_hit)
   );

   assign clearing  = ~clr_n;
   assign clr_fall  = clr_q & ~clr_n;
   assign modesel   = phy_ext ? pin_s[SEL_EXT] : pin_s[SEL_INT];
   assign link_rise = link_up & ~link_q;
   assign src_hit   = {magic_pkt, link_rise, pin_hit} & {NSRC{pme_mode}};
   assign any_hit   = |src_hit;
   assign trigger   = any_hit & ~pend & ~clearing;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clr_q      <= 1'b1;
         link_q     <= 1'b0;
         pme_mode   <= RESET_IN_PME;
         pend       <= 1'b0;
         wake_flags <= '0;
      end else begin
         clr_q  <= clr_n;
         link_q <= link_up;
         if (clr_fall) pme_mode <= modesel;
         if (clearing) begin
            pend       <= 1'b0;
            wake_flags <= '0;
         end else begin
            pend       <= pend | any_hit;
            wake_flags <= wake_flags | src_hit;
         end
      end
   end

   wpc_pme_out #(.PULSE_W(PULSE_W)) u_out (
      .clk(clk), .rst_n(rst_n), .trigger(trigger), .clearing(clearing),
      .pend(pend), .pulse_mode(pulse_mode), .pulse_len(pulse_len),
      .phy_ext(phy_ext), .open_drain(open_drain), .pme_sig(pme_sig),
      .gpio_out(gpio_out), .gpio_oe(gpio_oe)
   );
endmodule

// File: rtl/wake_pme_ctrl_chk.sv
module wake_pme_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        clr_n,
   input logic        pme_mode,
   input logic        modesel,
   input logic        pend,
   input logic        pme_sig,
   input logic        pulse_mode,
   input logic        open_drain,
   input logic [10:0] gpio_out,
   input logic [10:0] gpio_oe,
   input logic [12:0] wake_flags
);
   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |=> (!pend && wake_flags == '0));

   assert_no_wake_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!pme_mode && clr_n) |=> ((wake_flags & ~$past(wake_flags)) == '0));

   assert_mode_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clr_n) |=> (pme_mode == $past(modesel)));

   assert_level_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!pulse_mode && pend) |-> pme_sig);

   assert_pulse_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_mode && $rose(pme_sig)) |-> $rose(pend));

   assert_od_drive_R13: assert property (@(posedge clk) disable iff (!rst_n)
      open_drain |-> (gpio_out == '0));

   assert_one_pin_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gpio_oe));
endmodule

bind wake_pme_ctrl wake_pme_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .pme_mode(pme_mode),
   .modesel(modesel), .pend(pend), .pme_sig(pme_sig),
   .pulse_mode(pulse_mode), .open_drain(open_drain),
   .gpio_out(gpio_out), .gpio_oe(gpio_oe), .wake_flags(wake_flags)
);

// File: tb/wake_pme_ctrl_tb.sv
`timescale 1ns/1ps
module wake_pme_ctrl_tb;
   logic clk = 0, rst_n = 0, clr_n = 1, phy_ext = 0, g10h = 1, link_up = 0, magic = 0;
   logic pulse_mode = 0, open_drain = 0;
   logic [7:0]  pulse_len = 8'd3;
   logic [10:0] gpio_in = 11'b011_1111_1110, wake_en = '1;
   logic [10:0] gpio_out, gpio_oe;
   logic        pme_mode;
   logic [12:0] wake_flags;
   int total = 0, bad = 0;

   always #2.5 clk = ~clk;

   wake_pme_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .phy_ext(phy_ext), .gpio_in(gpio_in),
      .wake_en(wake_en), .g10_act_high(g10h), .link_up(link_up), .magic_pkt(magic),
      .pulse_mode(pulse_mode), .pulse_len(pulse_len), .open_drain(open_drain),
      .gpio_out(gpio_out), .gpio_oe(gpio_oe), .pme_mode(pme_mode), .wake_flags(wake_flags)
   );

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=0x%0h exp=0x%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   logic [10:0] hist[$];
   bit m_mode, m_pend, m_busy, m_clrprev, m_linkprev;
   int m_rem;
   logic [12:0] m_flags;

   function automatic logic [10:0] active(logic [10:0] v, bit hi10);
      logic [10:0] a = ~v;
      a[10] = hi10 ? v[10] : ~v[10];
      return a;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode = 1; m_pend = 0; m_busy = 0; m_rem = 0; m_flags = 0;
         m_clrprev = 1; m_linkprev = 0;
         hist = {11'd0, 11'd0, 11'd0};
      end else begin
         logic [10:0] s2, pv, cap, hits;
         logic [12:0] src;
         bit trig, msel;
         s2  = hist[hist.size()-2];
         pv  = hist[hist.size()-3];
         cap = phy_ext ? 11'h400 : 11'h7FC;
         hits = active(s2, g10h) & ~active(pv, g10h) & cap & wake_en;
         src = m_mode ? {magic, link_up & ~m_linkprev, hits} : 13'd0;
         trig = (src != 0) && !m_pend && clr_n;
         msel = phy_ext ? s2[9] : s2[1];
         if (!clr_n) m_busy = 0;
         else if (trig) begin m_busy = 1; m_rem = pulse_len; end
         else if (m_busy) begin
            if (m_rem == 0) m_busy = 0; else m_rem--;
         end
         if (m_clrprev && !clr_n) m_mode = msel;
         if (!clr_n) begin m_pend = 0; m_flags = 0; end
         else begin m_pend = m_pend | (src != 0); m_flags = m_flags | src; end
         hist.push_back(gpio_in);
         if (hist.size() > 8) void'(hist.pop_front());
         m_clrprev = clr_n;
         m_linkprev = link_up;
      end
   end

   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         bit sig;
         logic [10:0] pin, eo, ee;
         sig = pulse_mode ? m_busy : m_pend;
         pin = phy_ext ? 11'h100 : 11'h001;
         eo  = open_drain ? 11'd0 : (sig ? pin : 11'd0);
         ee  = open_drain ? (sig ? pin : 11'd0) : pin;
         chk("R2 model gpio_out", gpio_out, eo);
         chk("R13 model gpio_oe", gpio_oe, ee);
         chk("R9 model pme_mode", pme_mode, m_mode);
         chk("R12 model wake_flags", wake_flags, m_flags);
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_pulse();
      clr_n = 0; step(1); clr_n = 1;
   endtask

   function automatic int pme_pin();
      return phy_ext ? gpio_out[8] : gpio_out[0];
   endfunction

   initial begin
      #(200000 * 5);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int cnt;
      step(3); rst_n = 1;
      chk("R1 mode", pme_mode, 1); chk("R1 flags", wake_flags, 0);
      chk("R1 oe", gpio_oe, 11'h001); chk("R1 out", gpio_out, 0);
      step(4);
      // R4/R10: active-low gpio3 wakes, level held
      gpio_in[3] = 0; step(2);
      chk("R6 latency not yet", pme_pin(), 0);
      step(1);
      chk("R4 gpio3 pme", pme_pin(), 1);
      chk("R12 flag gpio3", wake_flags, 13'h0008);
      gpio_in[3] = 1; step(4);
      chk("R10 level hold", pme_pin(), 1);
      clear_pulse();
      chk("R8 flags cleared", wake_flags, 0); chk("R8 pme cleared", pme_pin(), 0);
      step(1); chk("R9 stay", pme_mode, 1);
      // R5: disabled pin
      wake_en[5] = 0; gpio_in[5] = 0; step(5);
      chk("R5 disabled pin", wake_flags, 0);
      gpio_in[5] = 1; step(4); wake_en[5] = 1;
      // R3: reserved pin 0 never wakes
      gpio_in[0] = 1; step(5); gpio_in[0] = 0; step(5);
      chk("R3 reserved pin", wake_flags, 0);
      // R4: gpio10 active low
      wake_en[10] = 0; g10h = 0; gpio_in[10] = 1; step(5);
      wake_en[10] = 1; gpio_in[10] = 0; step(4);
      chk("R4 gpio10 low polarity", wake_flags, 13'h0400);
      // R13 open drain
      open_drain = 1; step(1);
      chk("R13 od oe", gpio_oe, 11'h001); chk("R13 od out", gpio_out, 0);
      clear_pulse(); step(1);
      chk("R13 od released", gpio_oe, 0);
      open_drain = 0;
      // R3/R2 external mode
      phy_ext = 1; step(1);
      chk("R2 ext pin", gpio_oe, 11'h100);
      gpio_in[3] = 0; step(5);
      chk("R3 ext gpio3 ignored", wake_flags, 0);
      gpio_in[3] = 1; step(4);
      link_up = 1; step(1);
      chk("R6 link pme", pme_pin(), 1);
      chk("R6 link flag", wake_flags, 13'h0800);
      clear_pulse(); step(1);
      // R11 pulse
      pulse_mode = 1; pulse_len = 8'd3;
      magic = 1; step(1); magic = 0;
      cnt = pme_pin();
      for (int i = 0; i < 10; i++) begin step(1); cnt += pme_pin(); end
      chk("R11 pulse length", cnt, 4);
      chk("R12 magic flag", wake_flags, 13'h1000);
      magic = 1; step(1); magic = 0; cnt = 0;
      for (int i = 0; i < 8; i++) begin cnt += pme_pin(); step(1); end
      chk("R11 no second pulse", cnt, 0);
      clear_pulse(); step(1); pulse_mode = 0;
      // R9 leave, R7 ignore
      gpio_in[9] = 0; step(3);
      clear_pulse(); step(1);
      chk("R9 leave mode", pme_mode, 0);
      link_up = 0; step(1); link_up = 1; step(1);
      magic = 1; step(1); magic = 0;
      gpio_in[10] = 1; step(2); gpio_in[10] = 0; step(4);
      chk("R7 flags idle", wake_flags, 0); chk("R7 pme idle", pme_pin(), 0);
      gpio_in[9] = 1; step(3); clear_pulse(); step(1);
      chk("R9 re-enter", pme_mode, 1);
      // R8 clear wins
      clr_n = 0; magic = 1; step(1); magic = 0; clr_n = 1; step(1);
      chk("R8 clear precedence", wake_flags, 0);
      step(3);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule